// File: doc/BRIEF.md
# Two-Colour Hardware Cursor Overlay

This block places a 32 by 32 two-colour cursor over a scan-out pixel stream. Software loads the cursor shape and position through a small 32-bit register port. Each cursor row is described by two words. The first is a visibility mask. The second selects which of the two overlay colours is shown. The position register holds x in its upper half and y in its lower half.

During scan-out the block is given the current pixel coordinates, the underlying pixel colour, and the two overlay colours from an external palette. One clock later it presents either the underlying colour or a cursor colour. The valid flag is delayed by the same amount.

The cursor is parked off screen by reset. It appears only once software writes a position inside the active area. Cursor pixels that would fall to the right of the active width or below the active height are never shown.

Top module: `cursor_overlay`

## Requirements
- R1: After reset both cursor coordinates are 0xF000, every mask and data row is zero, the auxiliary register is zero, out_valid is 0 and out_color is 0. With shape rows loaded but no position written, screen pixels pass through unchanged.
- R2: A register write to offset 0x8FC sets cursor x from data bits 31:16 and cursor y from data bits 15:0.
- R3: A write to an offset from 0x900 to 0x97F loads mask row (offset-0x900)/4. A write to an offset from 0x980 to 0x9FF loads data row (offset-0x980)/4.
- R4: Within a cursor row, word bit 31 applies to column cursor x. Each lower bit applies to the next column to the right, so bit 0 applies to column x+31.
- R5: Where the mask bit is 0 the underlying colour passes through. Where the mask bit is 1, a data bit of 1 outputs overlay colour 3 and a data bit of 0 outputs overlay colour 2.
- R6: The cursor covers only rows y to y+31. Rows at or beyond the active height (default 768) are never overlaid.
- R7: The cursor is drawn only while cursor x is below the active width (default 1024). Columns at or beyond the active width are never overlaid.
- R8: The auxiliary register at offset 0x818 is writable. It reads back its stored value with bit 25 forced to 1. Every other offset reads as zero.
- R9: out_color and out_valid appear exactly one clock after the pixel inputs are presented. out_valid equals pix_valid from the previous cycle.
- R10: Writes to offsets outside the position, auxiliary, mask and data locations change neither the readable state nor the overlay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pix_valid | input | 1 | Pixel inputs are valid this cycle |
| pix_x | input | 16 | Current column |
| pix_y | input | 16 | Current row |
| pix_color | input | 24 | Underlying pixel colour |
| ovl_color2 | input | 24 | Overlay colour 2 (mask set, data clear) |
| ovl_color3 | input | 24 | Overlay colour 3 (mask set, data set) |
| out_valid | output | 1 | Output pixel valid |
| out_color | output | 24 | Output pixel colour |

## Verification
A corrupted position register shows up as a shifted or missing cursor on the first scanned pixel of the cursor box. A corrupted mask or data row shows up only on pixels in that row and column, so the tests probe both corners of the box and individual bit positions within a row. An off-by-one error in the clipping compare appears only at the exact screen-edge coordinates, so the bench samples the last active pixel and the first pixel past the edge. Errors in the output stage appear one clock after the pixel is presented, and the bench samples at that cycle.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int CUR_DIM = 32;
  localparam int IDX_W   = $clog2(CUR_DIM);
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 12;
  localparam int COORD_W = 16;
  localparam int COLOR_W = 24;

  localparam logic [ADDR_W-1:0] OFS_AUX  = 12'h818;
  localparam logic [ADDR_W-1:0] OFS_POS  = 12'h8FC;
  localparam logic [ADDR_W-1:0] OFS_MASK = 12'h900;
  localparam logic [ADDR_W-1:0] OFS_DATA = 12'h980;
  localparam logic [ADDR_W-1:0] ROW_SPAN = ADDR_W'(CUR_DIM * 4);

  localparam logic [COORD_W-1:0] PARK_POS = 16'hF000;
  localparam int AUX_FORCE_BIT = 25;

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_MASK,
    TGT_DATA
  } row_target_e;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] row;
    logic [IDX_W-1:0] col;
  } locate_t;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [REG_W-1:0]                 wdata,
  output logic [REG_W-1:0]                 rdata,
  output logic [COORD_W-1:0]               cur_x,
  output logic [COORD_W-1:0]               cur_y,
  output logic [CUR_DIM-1:0][REG_W-1:0]    mask_rows,
  output logic [CUR_DIM-1:0][REG_W-1:0]    data_rows
);
  logic [ADDR_W-1:0]  mask_off, data_off;
  row_target_e        target;
  logic [IDX_W-1:0]   row_idx;
  logic               pos_en, aux_en;
  logic [COORD_W-1:0] x_nxt, y_nxt;
  logic [REG_W-1:0]   aux_q, aux_nxt;

  // Address decode
  always_comb begin
    mask_off = addr - OFS_MASK;
    data_off = addr - OFS_DATA;
    target   = TGT_NONE;
    row_idx  = '0;
    if (addr >= OFS_MASK && addr < OFS_MASK + ROW_SPAN) begin
      target  = TGT_MASK;
      row_idx = mask_off[IDX_W+1:2];
    end else if (addr >= OFS_DATA && addr < OFS_DATA + ROW_SPAN) begin
      target  = TGT_DATA;
      row_idx = data_off[IDX_W+1:2];
    end
  end

  // Next state for the scalar registers
  always_comb begin
    pos_en  = wr_en && (addr == OFS_POS);
    aux_en  = wr_en && (addr == OFS_AUX);
    x_nxt   = wdata[2*COORD_W-1:COORD_W];
    y_nxt   = wdata[COORD_W-1:0];
    aux_nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_x <= PARK_POS;
      cur_y <= PARK_POS;
    end else if (pos_en) begin
      cur_x <= x_nxt;
      cur_y <= y_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_q <= '0;
    end else if (aux_en) begin
      aux_q <= aux_nxt;
    end
  end

  // One enabled register per cursor row, for each of the two planes
  for (genvar r = 0; r < CUR_DIM; r++) begin : g_row
    logic mask_en, data_en;
    always_comb begin
      mask_en = wr_en && (target == TGT_MASK) && (row_idx == IDX_W'(r));
      data_en = wr_en && (target == TGT_DATA) && (row_idx == IDX_W'(r));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_rows[r] <= '0;
      end else if (mask_en) begin
        mask_rows[r] <= wdata;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_rows[r] <= '0;
      end else if (data_en) begin
        data_rows[r] <= wdata;
      end
    end
  end

  // Read path
  always_comb begin
    rdata = '0;
    if (addr == OFS_AUX) begin
      rdata = aux_q;
      rdata[AUX_FORCE_BIT] = 1'b1;
    end
  end
endmodule

// File: rtl/cursor_locate.sv
module cursor_locate
  import cursor_pkg::*;
#(
  parameter int WIDTH  = 1024,
  parameter int HEIGHT = 768
) (
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic [COORD_W-1:0] cur_x,
  input  logic [COORD_W-1:0] cur_y,
  output locate_t            loc
);
  localparam logic [COORD_W:0] W_LIM = (COORD_W+1)'(WIDTH);
  localparam logic [COORD_W:0] H_LIM = (COORD_W+1)'(HEIGHT);

  logic [COORD_W:0] dx, dy;
  logic             in_x, in_y, on_screen, cur_ok;

  always_comb begin
    dx        = {1'b0, pix_x} - {1'b0, cur_x};
    dy        = {1'b0, pix_y} - {1'b0, cur_y};
    // A negative difference sets the top bit; within the box the difference is below CUR_DIM
    in_x      = !dx[COORD_W] && (dx[COORD_W-1:IDX_W] == '0);
    in_y      = !dy[COORD_W] && (dy[COORD_W-1:IDX_W] == '0);
    on_screen = ({1'b0, pix_x} < W_LIM) && ({1'b0, pix_y} < H_LIM);
    cur_ok    = {1'b0, cur_x} < W_LIM;
    loc.hit   = in_x && in_y && on_screen && cur_ok;
    loc.row   = dy[IDX_W-1:0];
    loc.col   = dx[IDX_W-1:0];
  end
endmodule

// File: rtl/cursor_mix.sv
module cursor_mix
  import cursor_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pix_valid,
  input  logic [COLOR_W-1:0]            pix_color,
  input  logic [COLOR_W-1:0]            ovl_color2,
  input  logic [COLOR_W-1:0]            ovl_color3,
  input  locate_t                       loc,
  input  logic [CUR_DIM-1:0][REG_W-1:0] mask_rows,
  input  logic [CUR_DIM-1:0][REG_W-1:0] data_rows,
  output logic                          out_valid,
  output logic [COLOR_W-1:0]            out_color
);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(CUR_DIM - 1);

  logic [IDX_W-1:0]   bit_idx;
  logic [REG_W-1:0]   mask_word, data_word;
  logic               show, pick3;
  logic [COLOR_W-1:0] color_nxt;

  always_comb begin
    bit_idx   = LAST_BIT - loc.col;
    mask_word = mask_rows[loc.row];
    data_word = data_rows[loc.row];
    show      = loc.hit && mask_word[bit_idx];
    pick3     = data_word[bit_idx];
    if (!show)      color_nxt = pix_color;
    else if (pick3) color_nxt = ovl_color3;
    else            color_nxt = ovl_color2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= pix_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_color <= '0;
    end else if (pix_valid) begin
      out_color <= color_nxt;
    end
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int WIDTH  = 1024,
  parameter int HEIGHT = 768
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [11:0]        reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               pix_valid,
  input  logic [15:0]        pix_x,
  input  logic [15:0]        pix_y,
  input  logic [23:0]        pix_color,
  input  logic [23:0]        ovl_color2,
  input  logic [23:0]        ovl_color3,
  output logic               out_valid,
  output logic [23:0]        out_color
);
  logic                          rst_meta_n, rst_q_n;
  logic [COORD_W-1:0]            cur_x, cur_y;
  logic [CUR_DIM-1:0][REG_W-1:0] mask_rows, data_rows;
  locate_t                       loc;

  // Asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  cursor_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .cur_x     (cur_x),
    .cur_y     (cur_y),
    .mask_rows (mask_rows),
    .data_rows (data_rows)
  );

  cursor_locate #(.WIDTH(WIDTH), .HEIGHT(HEIGHT)) u_locate (
    .pix_x (pix_x),
    .pix_y (pix_y),
    .cur_x (cur_x),
    .cur_y (cur_y),
    .loc   (loc)
  );

  cursor_mix u_mix (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .pix_valid  (pix_valid),
    .pix_color  (pix_color),
    .ovl_color2 (ovl_color2),
    .ovl_color3 (ovl_color3),
    .loc        (loc),
    .mask_rows  (mask_rows),
    .data_rows  (data_rows),
    .out_valid  (out_valid),
    .out_color  (out_color)
  );
endmodule

// File: rtl/cursor_overlay_checker.sv
module cursor_overlay_checker
  import cursor_pkg::*;
#(
  parameter int WIDTH = 1024
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [11:0]        reg_addr,
  input logic [31:0]        reg_wdata,
  input logic [31:0]        reg_rdata,
  input logic               pix_valid,
  input logic [23:0]        pix_color,
  input logic [23:0]        ovl_color2,
  input logic [23:0]        ovl_color3,
  input logic               out_valid,
  input logic [23:0]        out_color,
  input logic [15:0]        cur_x,
  input logic [15:0]        cur_y
);
  localparam logic [16:0] W_LIM = 17'(WIDTH);

  assert_pos_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_POS) |=>
      (cur_x == $past(reg_wdata[31:16]) && cur_y == $past(reg_wdata[15:0])));

  assert_pos_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == OFS_POS) |=> ($stable(cur_x) && $stable(cur_y)));

  assert_aux_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_AUX) |-> reg_rdata[AUX_FORCE_BIT]);

  assert_other_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != OFS_AUX) |-> (reg_rdata == '0));

  assert_valid_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);

  assert_idle_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);

  assert_colour_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> (out_color == $past(pix_color) || out_color == $past(ovl_color2) ||
                   out_color == $past(ovl_color3)));

  assert_parked_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && {1'b0, cur_x} >= W_LIM) |=> (out_color == $past(pix_color)));
endmodule

bind cursor_overlay cursor_overlay_checker #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .pix_valid  (pix_valid),
  .pix_color  (pix_color),
  .ovl_color2 (ovl_color2),
  .ovl_color3 (ovl_color3),
  .out_valid  (out_valid),
  .out_color  (out_color),
  .cur_x      (cur_x),
  .cur_y      (cur_y)
);

// File: tb/cursor_overlay_test.sv
`timescale 1ns/1ps
module cursor_overlay_test;
  localparam int W = 1024;
  localparam int H = 768;
  localparam logic [23:0] C2 = 24'h222222;
  localparam logic [23:0] C3 = 24'h333333;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        pix_valid;
  logic [15:0] pix_x, pix_y;
  logic [23:0] pix_color;
  logic        out_valid;
  logic [23:0] out_color;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench model of the programmed state
  logic [31:0] m_mask [32];
  logic [31:0] m_data [32];
  int          m_cx, m_cy;

  always #2.5 clk = ~clk;

  cursor_overlay #(.WIDTH(W), .HEIGHT(H)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_valid(pix_valid),
    .pix_x(pix_x), .pix_y(pix_y), .pix_color(pix_color),
    .ovl_color2(C2), .ovl_color3(C3), .out_valid(out_valid), .out_color(out_color)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 12'h8FC) begin m_cx = int'(d[31:16]); m_cy = int'(d[15:0]); end
    if (a >= 12'h900 && a < 12'h980) m_mask[(a - 12'h900) >> 2] = d;
    if (a >= 12'h980 && a < 12'hA00) m_data[(a - 12'h980) >> 2] = d;
  endtask

  task automatic reg_read_check(string req, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  function automatic logic [23:0] model_px(int x, int y, logic [23:0] base);
    int dx, dy;
    dx = x - m_cx; dy = y - m_cy;
    if (x < W && y < H && m_cx < W && dx >= 0 && dx < 32 && dy >= 0 && dy < 32)
      if (m_mask[dy][31-dx]) return m_data[dy][31-dx] ? C3 : C2;
    return base;
  endfunction

  // Present one pixel, then sample the registered result one clock later
  task automatic pixel_check(string req, int x, int y, logic [23:0] base, logic [23:0] exp);
    @(negedge clk);
    pix_valid = 1'b1; pix_x = 16'(x); pix_y = 16'(y); pix_color = base;
    @(negedge clk);
    pix_valid = 1'b0;
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check(req, {8'd0, out_color}, {8'd0, exp});
    check({req, " model"}, {8'd0, exp}, {8'd0, model_px(x, y, base)});
  endtask

  task automatic t_reset_state();
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 out_color", {8'd0, out_color}, 32'd0);
    reg_read_check("R1 aux", 12'h818, 32'h0200_0000);
    reg_write(12'h900, 32'hFFFF_FFFF);
    reg_write(12'h980, 32'hFFFF_FFFF);
    pixel_check("R1 parked", 0, 0, 24'h0A0B0C, 24'h0A0B0C);
    reg_write(12'h900, 32'h0);
    reg_write(12'h980, 32'h0);
  endtask

  task automatic t_aux_reg();
    reg_write(12'h818, 32'h0000_0055);
    reg_read_check("R8 aux", 12'h818, 32'h0200_0055);
    reg_read_check("R8 other", 12'h900, 32'h0);
    reg_read_check("R8 pos", 12'h8FC, 32'h0);
  endtask

  task automatic t_ignored_write();
    reg_write(12'h800, 32'hDEAD_BEEF);
    reg_write(12'h81C, 32'h1234_5678);
    reg_read_check("R10 aux kept", 12'h818, 32'h0200_0055);
    pixel_check("R10 still parked", 5, 5, 24'h111111, 24'h111111);
  endtask

  task automatic t_shape_bits();
    reg_write(12'h900, 32'hF000_0000);
    reg_write(12'h980, 32'hA000_0000);
    reg_write(12'h97C, 32'h0000_0001);
    reg_write(12'h9FC, 32'h0000_0001);
    reg_write(12'h8FC, {16'd100, 16'd200});
    pixel_check("R4 col0", 100, 200, 24'h5A5A5A, C3);
    pixel_check("R5 col1 data0", 101, 200, 24'h5A5A5A, C2);
    pixel_check("R4 col2", 102, 200, 24'h5A5A5A, C3);
    pixel_check("R5 col3", 103, 200, 24'h5A5A5A, C2);
    pixel_check("R5 mask0 pass", 104, 200, 24'h5A5A5A, 24'h5A5A5A);
    pixel_check("R2 left of box", 99, 200, 24'h5A5A5A, 24'h5A5A5A);
    pixel_check("R3 last row bit0", 131, 231, 24'h010203, C3);
    pixel_check("R4 past last col", 132, 231, 24'h010203, 24'h010203);
    pixel_check("R6 below box", 131, 232, 24'h010203, 24'h010203);
    pixel_check("R6 above box", 100, 199, 24'h010203, 24'h010203);
  endtask

  task automatic t_bottom_clip();
    reg_write(12'h91C, 32'hFFFF_FFFF);
    reg_write(12'h920, 32'hFFFF_FFFF);
    reg_write(12'h8FC, {16'd10, 16'd760});
    pixel_check("R6 last screen row", 12, 767, 24'h777777, C2);
    pixel_check("R6 off screen row", 12, 768, 24'h777777, 24'h777777);
  endtask

  task automatic t_right_clip();
    reg_write(12'h900, 32'hFFFF_FFFF);
    reg_write(12'h980, 32'h0000_0000);
    reg_write(12'h8FC, {16'd1020, 16'd0});
    pixel_check("R7 last column", 1023, 0, 24'h444444, C2);
    pixel_check("R7 past width", 1024, 0, 24'h444444, 24'h444444);
    reg_write(12'h8FC, {16'd1024, 16'd0});
    pixel_check("R7 cursor x at width", 1024, 0, 24'h454545, 24'h454545);
  endtask

  task automatic t_latency();
    @(negedge clk);
    pix_valid = 1'b0;
    @(negedge clk);
    check("R9 idle", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    pix_valid = 1'b1; pix_x = 16'd300; pix_y = 16'd300; pix_color = 24'h999999;
    #1;
    check("R9 not yet", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    pix_valid = 1'b0;
    check("R9 one clock", {8'd0, out_color}, 32'h0099_9999);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin m_mask[i] = '0; m_data[i] = '0; end
    m_cx = 16'hF000; m_cy = 16'hF000;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    pix_valid = 1'b0; pix_x = '0; pix_y = '0; pix_color = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_aux_reg();
    t_ignored_write();
    t_shape_bits();
    t_bottom_clip();
    t_right_clip();
    t_latency();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule